// File: doc/BRIEF.md
# Hold Request Conversion Scheduler

This block sits in front of a dual-channel converter that is shared by three channel-pair groups, A, B and C. Each group owns an active-low hold input. A falling edge on a hold input asks for one conversion of that group's two channels. The scheduler detects these edges on the falling clock edge and places each new request in an ordered queue. It starts one conversion slot at a time on a rising clock edge.

While a slot runs, the block drives an active-low busy output. Partway through the slot it pulses a latch strobe that carries the group identifier and two 12-bit results. The result store downstream uses this strobe to file the X0 and X1 data of that group. The conversion datapath is a stub: a fixed clock-count delay whose results encode the group and a running conversion number, so that every hand-over can be identified.

Top module: `hold_sched`

## Requirements
- R1: A hold input is sampled on each falling clock edge. A request is registered only when the previous sample was high and the current sample is low. A hold input that stays low starts exactly one conversion.
- R2: While a group is waiting in the queue or its 16-cycle slot is running (the last slot cycle included), more falling edges on its hold input are ignored. After the slot ends, a new edge is accepted again.
- R3: hold_ni bit 0 is group A, bit 1 is B and bit 2 is C. Requests detected at the same falling edge are queued in the order A, B, C.
- R4: Requests detected at different falling edges are served in arrival order. A request that arrives while a slot runs waits until the converter is free.
- R5: If the converter is free, a request detected at a falling edge starts its slot on the next rising edge. busy_no is low for exactly 13 cycles from that rising edge and is high otherwise.
- R6: latch_o is high for exactly one cycle per slot: the 13th busy-low cycle. In that cycle, latch_grp_o gives the group (A=0, B=1, C=2). res0_o is {group[1:0], n[9:0]}, where n is the number of slots started since reset before this one. res1_o is the bitwise inverse of res0_o.
- R7: When requests are queued, successive slots start exactly 16 cycles apart.
- R8: An asserted rst_ni immediately drives busy_no high and latch_o low. It cancels the running slot and every queued request, and it restarts the slot count n at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_ni | input | 3 | Active-low hold requests, bit 0 = A, 1 = B, 2 = C |
| busy_no | output | 1 | Low while a conversion is in progress |
| latch_o | output | 1 | One-cycle result hand-over strobe |
| latch_grp_o | output | 2 | Group of the results being handed over |
| res0_o | output | 12 | Stub result of channel X0 |
| res1_o | output | 12 | Stub result of channel X1 |

## Verification
The bench holds a hold input low for a long time; a design that triggered on the level would convert that group again and again. It drops all three holds together, then at staggered times. A wrong priority or a last-in order shows up as a permuted sequence of latched groups. It toggles a hold input repeatedly while that group is queued and while its slot runs, which exposes a design that queues a group twice. It also fires a reset in the middle of a slot: a design that kept the slot or the queue would still produce a late strobe or a stale conversion number.

// File: rtl/hsched_pkg.sv
package hsched_pkg;
  localparam int GRP_W = 2;
  typedef logic [GRP_W-1:0] grp_t;
endpackage

// File: rtl/hsched_edge.sv
module hsched_edge #(
  parameter int N_GRP = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_GRP-1:0] hold_ni,
  output logic [N_GRP-1:0] req_o
);
  logic [N_GRP-1:0] hold_q;

  // sampled on the falling clock edge; the previous sample makes a level a one-shot
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '1;
      req_o  <= '0;
    end else begin
      hold_q <= hold_ni;
      req_o  <= hold_q & ~hold_ni;
    end
  end

  p_req_low_r1: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (req_o & hold_q) == '0);
  p_req_once_r1: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (req_o & $past(req_o)) == '0);
endmodule

// File: rtl/hsched_queue.sv
module hsched_queue
  import hsched_pkg::*;
#(
  parameter int N_GRP = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_GRP-1:0] req_i,
  input  logic [N_GRP-1:0] lock_i,
  input  logic             free_i,
  output logic             start_o,
  output grp_t             start_grp_o
);
  localparam int CNT_W = $clog2(N_GRP + 1);

  grp_t             q_grp [N_GRP];
  logic [CNT_W-1:0] q_cnt;
  grp_t             n_grp [N_GRP];
  logic [CNT_W-1:0] n_cnt;
  logic [N_GRP-1:0] pend, add;

  always_comb begin
    pend = '0;
    for (int i = 0; i < N_GRP; i++)
      if (CNT_W'(i) < q_cnt) pend[q_grp[i]] = 1'b1;
  end

  assign add = req_i & ~pend & ~lock_i;

  always_comb begin
    n_grp = q_grp;
    n_cnt = q_cnt;
    // lower index wins inside one cycle
    for (int g = 0; g < N_GRP; g++) begin
      if (add[g]) begin
        n_grp[n_cnt] = grp_t'(g);
        n_cnt        = n_cnt + 1'b1;
      end
    end
    start_o     = free_i && (n_cnt != '0);
    start_grp_o = n_grp[0];
    if (start_o) begin
      for (int i = 0; i < N_GRP - 1; i++) n_grp[i] = n_grp[i+1];
      n_cnt = n_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_cnt <= '0;
      for (int i = 0; i < N_GRP; i++) q_grp[i] <= '0;
    end else begin
      q_cnt <= n_cnt;
      q_grp <= n_grp;
    end
  end

  p_no_dup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pend) == int'(q_cnt));
  p_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(q_cnt) <= N_GRP);
  p_lock_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend & lock_i) == '0);
endmodule

// File: rtl/hsched_slot.sv
module hsched_slot
  import hsched_pkg::*;
#(
  parameter int SLOT_CYC  = 16,
  parameter int BUSY_CYC  = 13,
  parameter int LATCH_CYC = 12,
  parameter int RES_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  grp_t             start_grp_i,
  output logic             free_o,
  output logic             act_o,
  output grp_t             grp_o,
  output logic             busy_no,
  output logic             latch_o,
  output logic [RES_W-1:0] res0_o,
  output logic [RES_W-1:0] res1_o
);
  localparam int CW    = $clog2(SLOT_CYC);
  localparam int SEQ_W = RES_W - GRP_W;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

  logic             act;
  logic [CW-1:0]    cnt;
  grp_t             grp;
  logic [SEQ_W-1:0] seq;
  logic [RES_W-1:0] tag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act <= 1'b0;
      cnt <= '0;
      grp <= '0;
      seq <= '0;
      tag <= '0;
    end else if (start_i) begin
      act <= 1'b1;
      cnt <= '0;
      grp <= start_grp_i;
      tag <= {start_grp_i, seq};
      seq <= seq + 1'b1;
    end else if (act) begin
      if (cnt == LAST) act <= 1'b0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign free_o  = !act || (cnt == LAST);
  assign act_o   = act;
  assign grp_o   = grp;
  assign busy_no = !(act && (int'(cnt) < BUSY_CYC));
  assign latch_o = act && (int'(cnt) == LATCH_CYC);
  assign res0_o  = tag;
  assign res1_o  = ~tag;

  p_busy_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_no) |-> $past(start_i));
  p_latch_in_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> !busy_no);
  p_latch_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> busy_no);
  p_spacing_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && act) |-> (cnt == LAST));
endmodule

// File: rtl/hold_sched.sv
module hold_sched
  import hsched_pkg::*;
#(
  parameter int N_GRP     = 3,
  parameter int SLOT_CYC  = 16,
  parameter int BUSY_CYC  = 13,
  parameter int LATCH_CYC = 12,
  parameter int RES_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_GRP-1:0] hold_ni,
  output logic             busy_no,
  output logic             latch_o,
  output logic [GRP_W-1:0] latch_grp_o,
  output logic [RES_W-1:0] res0_o,
  output logic [RES_W-1:0] res1_o
);
  logic [N_GRP-1:0] req, lock;
  logic             free, start, act;
  grp_t             start_grp, grp;

  hsched_edge #(.N_GRP(N_GRP)) u_edge (
    .clk_i, .rst_ni, .hold_ni, .req_o(req)
  );

  hsched_queue #(.N_GRP(N_GRP)) u_queue (
    .clk_i, .rst_ni, .req_i(req), .lock_i(lock), .free_i(free),
    .start_o(start), .start_grp_o(start_grp)
  );

  hsched_slot #(
    .SLOT_CYC(SLOT_CYC), .BUSY_CYC(BUSY_CYC), .LATCH_CYC(LATCH_CYC), .RES_W(RES_W)
  ) u_slot (
    .clk_i, .rst_ni, .start_i(start), .start_grp_i(start_grp),
    .free_o(free), .act_o(act), .grp_o(grp),
    .busy_no, .latch_o, .res0_o, .res1_o
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_lock
    assign lock[g] = act && (grp == grp_t'(g));
  end

  assign latch_grp_o = grp;

  initial begin
    assert (N_GRP <= (1 << GRP_W));
    assert (LATCH_CYC < BUSY_CYC && BUSY_CYC <= SLOT_CYC);
  end
endmodule

// File: tb/hold_sched_test.sv
module hold_sched_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  hold_n = 3'b111;
  logic        busy_no, latch_o;
  logic [1:0]  latch_grp_o;
  logic [11:0] res0_o, res1_o;

  hold_sched uut (
    .clk_i(clk), .rst_ni, .hold_ni(hold_n), .busy_no, .latch_o,
    .latch_grp_o, .res0_o, .res1_o
  );

  always #2 clk = ~clk;

  int vecs = 0, errs = 0;
  bit done = 0;

  // reference model
  logic [2:0] m_prev = 3'b111, m_edge = 3'b000;
  always @(negedge clk) begin
    if (!rst_ni) begin
      m_prev <= 3'b111;
      m_edge <= 3'b000;
    end else begin
      m_edge <= m_prev & ~hold_n;
      m_prev <= hold_n;
    end
  end

  int q[$];
  int got[$];
  int falls[$];
  bit m_act = 0;
  int m_cnt = 0, m_grp = 0, m_seq = 0, m_tag = 0, cyc_no = 0;
  logic prev_busy = 1'b1;

  task automatic fail(string r, int a, int e);
    errs++;
    $display("FAIL %s: got %0h expected %0h", r, a, e);
  endtask

  task automatic model_reset();
    q.delete();
    m_act = 0; m_cnt = 0; m_grp = 0; m_seq = 0; m_tag = 0;
  endtask

  task automatic step();
    bit free, inq, e_busy, e_latch;
    int lockg;
    @(posedge clk); #1;
    cyc_no++;
    free  = !m_act || (m_cnt == 15);
    lockg = m_act ? m_grp : -1;
    for (int g = 0; g < 3; g++) begin
      inq = 0;
      foreach (q[i]) if (q[i] == g) inq = 1;
      if (m_edge[g] && !inq && g != lockg) q.push_back(g);
    end
    if (m_act) begin
      if (m_cnt == 15) m_act = 0;
      else m_cnt++;
    end
    if (free && q.size() > 0) begin
      m_act = 1; m_cnt = 0; m_grp = q.pop_front();
      m_tag = (m_grp << 10) | (m_seq & 1023);
      m_seq++;
    end
    e_busy  = !(m_act && m_cnt < 13);
    e_latch = m_act && m_cnt == 12;
    vecs++;
    if (busy_no !== e_busy) fail("R5 R7 busy_no", busy_no, e_busy);
    if (latch_o !== e_latch) fail("R6 latch_o", latch_o, e_latch);
    if (e_latch) begin
      if (latch_grp_o !== 2'(m_grp)) fail("R3 R4 latch_grp_o", latch_grp_o, m_grp);
      if (res0_o !== 12'(m_tag)) fail("R6 res0_o", res0_o, m_tag);
      if (res1_o !== ~12'(m_tag)) fail("R6 res1_o", res1_o, (~m_tag) & 12'hfff);
    end
    if (latch_o === 1'b1) got.push_back(int'(latch_grp_o));
    if (prev_busy === 1'b1 && busy_no === 1'b0) falls.push_back(cyc_no);
    prev_busy = busy_no;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk_list(string r, int e[$]);
    vecs++;
    if (got.size() != e.size()) fail({r, " count"}, got.size(), e.size());
    else foreach (e[i]) if (got[i] != e[i]) fail({r, " order"}, got[i], e[i]);
    got.delete();
  endtask

  task automatic pulse(logic [2:0] low);
    hold_n = ~low; step(); hold_n = 3'b111;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    vecs++; if (busy_no !== 1'b1) fail("R8 busy_no", busy_no, 1);
    vecs++; if (latch_o !== 1'b0) fail("R8 latch_o", latch_o, 0);
    repeat (3) @(posedge clk);
    #1;
    model_reset();
    got.delete(); falls.delete();
    prev_busy = 1'b1;
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    do_reset();
    cyc(4);
    // R1: held low converts once
    hold_n = 3'b110; cyc(50); hold_n = 3'b111; cyc(5);
    chk_list("R1", '{0});
    // R3: same-cycle priority
    pulse(3'b111); cyc(60);
    chk_list("R3", '{0, 1, 2});
    // R4: arrival order
    pulse(3'b100); cyc(3); pulse(3'b001); cyc(2); pulse(3'b010); cyc(60);
    chk_list("R4", '{2, 0, 1});
    // R2: repeats while queued or running are ignored
    pulse(3'b001); step();
    for (int k = 0; k < 3; k++) begin pulse(3'b010); step(); end
    pulse(3'b001); cyc(8);
    for (int k = 0; k < 3; k++) begin pulse(3'b010); step(); end
    cyc(50);
    chk_list("R2", '{0, 1});
    pulse(3'b010); cyc(30);
    chk_list("R2 accepted after slot", '{1});
    // R7: back-to-back spacing
    falls.delete();
    pulse(3'b111); cyc(60);
    chk_list("R7 groups", '{0, 1, 2});
    vecs++;
    if (falls.size() != 3) fail("R7 starts", falls.size(), 3);
    else begin
      if (falls[1] - falls[0] != 16) fail("R7 spacing", falls[1] - falls[0], 16);
      if (falls[2] - falls[1] != 16) fail("R7 spacing", falls[2] - falls[1], 16);
    end
    // R8: reset mid-slot cancels slot and queue
    pulse(3'b111); cyc(6);
    do_reset();
    cyc(40);
    chk_list("R8 cancel", '{});
    pulse(3'b100); cyc(30);
    chk_list("R8 restart", '{2});
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule